// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block is the home node for a small group of memory blocks in a distributed shared-memory machine with a parameterised number of nodes. For every block it stores a directory entry and the block's data. Each entry has a coherence state (Uncached, Shared or Exclusive) and a presence vector with one bit per node. Requesting nodes send read misses, write misses and write-backs on a valid/ready request channel.

The directory reads the entry for the addressed block. It then sends invalidate or fetch probes only to the nodes whose presence bits are set, one probe at a time, and waits for each acknowledgement. After the last acknowledgement it returns the block's data to the requester on a reply channel. Only one transaction is in flight at a time. A request that arrives while an earlier one is still waiting on probes is held off by a low `req_ready` until the reply has been taken.

Encodings on the ports are as follows:
- Request kind: 0 = read miss, 1 = write miss, 2 = write-back, 3 = no operation.
- Probe kind: 0 = invalidate, 1 = fetch and keep a shared copy, 2 = fetch and invalidate.

Top module: `coh_home_dir`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and `prb_valid` and `rsp_valid` are 0. Every block starts Uncached with an empty presence vector and all-zero data.
- R2: A read miss (kind 0) to an Uncached or Shared block sends no probe. `rsp_valid` rises in the second cycle after the accepting edge, carrying the requester's node, the address and the block's stored data. The requester is then recorded as a holder and the block becomes Shared.
- R3: A write miss (kind 1) to a Shared block sends an invalidate (probe kind 0) to every holder except the requester, then replies. Afterwards the requester is the only holder and the block is Exclusive.
- R4: A miss to an Exclusive block sends one probe to the owner: kind 1 for a read, kind 2 for a write. The `ack_data` returned is written into the block's memory before the reply, and the reply carries that value. After a read, owner and requester both hold Shared copies. After a write, the requester owns the block.
- R5: A write-back (kind 2) from the owner of an Exclusive block stores `req_data` into the block and makes it Uncached with no holders. It produces no reply and no probe, and `req_ready` is 1 again in the second cycle after the accepting edge.
- R6: A write-back from a node that does not own the block, a write-back to a block that is not Exclusive, and request kind 3 all leave data and directory unchanged. Each produces no reply and no probe.
- R7: Probes go out one at a time in ascending node order. The next probe is issued only after the previous one has been acknowledged. Each probe becomes valid in the second cycle after the accepting edge, or in the cycle right after the previous acknowledgement.
- R8: `req_ready` is 1 only while no transaction is in progress. It stays 0 from the accepting edge until the reply has been taken, or, for a request with no reply, for the one evaluation cycle.
- R9: A probe or reply that is presented and not taken keeps its valid high and its node, kind, address and data unchanged.
- R10: The requesting node is never probed. A copy the requester already holds counts as its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 no operation |
| req_node | input | NID_W | Requesting node |
| req_addr | input | ADDR_W | Block index |
| req_data | input | DATA_W | Write-back data |
| prb_valid | output | 1 | Probe present |
| prb_ready | input | 1 | Probe taken on this edge when valid |
| prb_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch and invalidate |
| prb_node | output | NID_W | Node being probed |
| prb_addr | output | ADDR_W | Block being probed |
| ack_valid | input | 1 | Acknowledgement of the outstanding probe |
| ack_ready | output | 1 | Directory waiting for an acknowledgement |
| ack_data | input | DATA_W | Block data returned by a fetch |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply taken on this edge when valid |
| rsp_node | output | NID_W | Node the reply is for |
| rsp_addr | output | ADDR_W | Block of the reply |
| rsp_data | output | DATA_W | Block data |

## Verification
Each result has a fixed cycle after the event that causes it:
- A request is taken on the edge where it is driven.
- One edge later the directory is still evaluating, and the bench checks that nothing is presented and `req_ready` is low.
- On the second edge, one of three things holds. The first probe is valid, or the reply is valid if no probe is needed, or `req_ready` is back for a request with no reply.
- After each acknowledgement, the next probe or the reply is checked on the very next sampling point.

The bench drives and samples on falling edges, so each of these points is a single sample. A random number of stall cycles on the probe, acknowledgement and reply sides checks that values stay stable and that the order holds for any handshake delay. A bench-side model of states, holders and data supplies the expected probe list and reply data.

// File: rtl/coh_dir_pkg.sv
// Shared encodings for the home-node coherence directory.
// Assumes all codes fit the 2-bit fields carried on the block's ports.
package coh_dir_pkg;

    typedef enum logic [1:0] {
        DS_UNC = 2'd0,
        DS_SHR = 2'd1,
        DS_EXC = 2'd2
    } dir_st_t;

    typedef enum logic [1:0] {
        RQ_RD  = 2'd0,
        RQ_WR  = 2'd1,
        RQ_WB  = 2'd2,
        RQ_NOP = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        PB_INV       = 2'd0,
        PB_FETCH     = 2'd1,
        PB_FETCH_INV = 2'd2
    } probe_kind_t;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_EVAL  = 3'd1,
        FS_PROBE = 3'd2,
        FS_WAIT  = 3'd3,
        FS_REPLY = 3'd4
    } ctl_st_t;

endpackage

// File: rtl/coh_dir_store.sv
// Directory entries and block data for every block of the home node.
// Reads are combinational from one address; writes take effect at the edge.
// Assumes BLOCKS is a power of two so every address selects an entry.
module coh_dir_store
    import coh_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 4,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        rd_state,
    output logic [NODES-1:0]  rd_holders,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dir_we,
    input  logic [1:0]        dir_state_in,
    input  logic [NODES-1:0]  dir_holders_in,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_data_in
);

    dir_st_t           st_q  [BLOCKS];
    logic [NODES-1:0]  hld_q [BLOCKS];
    logic [DATA_W-1:0] mem_q [BLOCKS];

    // Read port: present the entry and data of the selected block.
    assign rd_state   = st_q[addr];
    assign rd_holders = hld_q[addr];
    assign rd_data    = mem_q[addr];

    // Directory update: clear on reset, else write the selected entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                st_q[b]  <= DS_UNC;
                hld_q[b] <= '0;
            end
        end else if (dir_we) begin
            st_q[addr]  <= dir_st_t'(dir_state_in);
            hld_q[addr] <= dir_holders_in;
        end
    end

    // Data update: clear on reset, else write the selected block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                mem_q[b] <= '0;
            end
        end else if (mem_we) begin
            mem_q[addr] <= mem_data_in;
        end
    end

    for (genvar g = 0; g < BLOCKS; g++) begin : g_entry_chk
        AST_EXC_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            st_q[g] == DS_EXC |-> $countones(hld_q[g]) == 1);   // R4
        AST_UNC_NO_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
            st_q[g] == DS_UNC |-> hld_q[g] == '0);               // R5
        AST_SHR_HAS_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
            st_q[g] == DS_SHR |-> hld_q[g] != '0);               // R2
    end

endmodule

// File: rtl/coh_dir_pick.sv
// Selects the lowest-numbered node with a pending probe.
// Assumes NODES >= 2; returns 0 when nothing is pending.
module coh_dir_pick #(
    parameter int NODES = 4,
    localparam int NID_W = $clog2(NODES)
) (
    input  logic [NODES-1:0] pend,
    output logic [NID_W-1:0] idx
);

    // Priority scan: the last hit from the top is the lowest set bit.
    always_comb begin
        idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (pend[i]) idx = NID_W'(i);
        end
    end

endmodule

// File: rtl/coh_dir_policy.sv
// Coherence policy: from the request and the current entry, decides which
// nodes to probe, the probe kind, the entry after completion, whether a
// reply is due and whether a write-back is accepted. Purely combinational.
module coh_dir_policy
    import coh_dir_pkg::*;
#(
    parameter int NODES = 4,
    localparam int NID_W = $clog2(NODES)
) (
    input  logic [1:0]       kind,
    input  logic [NID_W-1:0] node,
    input  logic [1:0]       cur_state,
    input  logic [NODES-1:0] cur_holders,
    output logic [NODES-1:0] probe_mask,
    output logic [1:0]       probe_kind,
    output logic [1:0]       next_state,
    output logic [NODES-1:0] next_holders,
    output logic             need_reply,
    output logic             wb_take
);

    localparam logic [NODES-1:0] ONE = NODES'(1);

    logic [NODES-1:0] self_bit;
    assign self_bit = ONE << node;

    // Decision table per request kind; the requester is never probed.
    always_comb begin
        probe_mask   = '0;
        probe_kind   = PB_INV;
        next_state   = cur_state;
        next_holders = cur_holders;
        need_reply   = 1'b0;
        wb_take      = 1'b0;
        case (req_kind_t'(kind))
            RQ_RD: begin
                need_reply   = 1'b1;
                next_state   = DS_SHR;
                next_holders = cur_holders | self_bit;
                if (cur_state == DS_EXC) begin
                    probe_mask = cur_holders & ~self_bit;
                    probe_kind = PB_FETCH;
                end
            end
            RQ_WR: begin
                need_reply   = 1'b1;
                next_state   = DS_EXC;
                next_holders = self_bit;
                probe_mask   = cur_holders & ~self_bit;
                probe_kind   = (cur_state == DS_EXC) ? PB_FETCH_INV : PB_INV;
            end
            RQ_WB: begin
                if (cur_state == DS_EXC && cur_holders == self_bit) begin
                    wb_take      = 1'b1;
                    next_state   = DS_UNC;
                    next_holders = '0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/coh_home_dir.sv
// Home-node coherence directory: accepts one request at a time, evaluates
// the entry, issues targeted probes serially in ascending node order,
// folds fetched data into memory and replies to the requester.
// Assumes a probed node answers each probe with exactly one acknowledgement.
module coh_home_dir
    import coh_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 4,
    parameter int DATA_W = 16,
    localparam int NID_W  = $clog2(NODES),
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [NID_W-1:0]  req_node,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              prb_valid,
    input  logic              prb_ready,
    output logic [1:0]        prb_kind,
    output logic [NID_W-1:0]  prb_node,
    output logic [ADDR_W-1:0] prb_addr,
    input  logic              ack_valid,
    output logic              ack_ready,
    input  logic [DATA_W-1:0] ack_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [NID_W-1:0]  rsp_node,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_data
);

    localparam logic [NODES-1:0] ONE = NODES'(1);

    ctl_st_t           fs_q;
    logic [1:0]        cur_kind_q;
    logic [NID_W-1:0]  cur_node_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [DATA_W-1:0] cur_data_q;
    logic [NODES-1:0]  pend_q;
    logic [1:0]        pkind_q;
    logic [1:0]        nst_q;
    logic [NODES-1:0]  nhld_q;
    logic [NID_W-1:0]  tgt_q;

    logic [1:0]        st_rd;
    logic [NODES-1:0]  hld_rd;
    logic [DATA_W-1:0] data_rd;
    logic [NODES-1:0]  pol_mask;
    logic [1:0]        pol_pkind;
    logic [1:0]        pol_nst;
    logic [NODES-1:0]  pol_nhld;
    logic              pol_reply;
    logic              pol_take;
    logic [NID_W-1:0]  pick_idx;
    logic [NODES-1:0]  pend_left;

    logic              dir_we;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;

    coh_dir_store #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .addr           (cur_addr_q),
        .rd_state       (st_rd),
        .rd_holders     (hld_rd),
        .rd_data        (data_rd),
        .dir_we         (dir_we),
        .dir_state_in   (fs_q == FS_EVAL ? pol_nst : nst_q),
        .dir_holders_in (fs_q == FS_EVAL ? pol_nhld : nhld_q),
        .mem_we         (mem_we),
        .mem_data_in    (mem_wdata)
    );

    coh_dir_policy #(.NODES(NODES)) u_policy (
        .kind         (cur_kind_q),
        .node         (cur_node_q),
        .cur_state    (st_rd),
        .cur_holders  (hld_rd),
        .probe_mask   (pol_mask),
        .probe_kind   (pol_pkind),
        .next_state   (pol_nst),
        .next_holders (pol_nhld),
        .need_reply   (pol_reply),
        .wb_take      (pol_take)
    );

    coh_dir_pick #(.NODES(NODES)) u_pick (
        .pend (pend_q),
        .idx  (pick_idx)
    );

    // Pending probes once the outstanding acknowledgement is counted.
    assign pend_left = pend_q & ~(ONE << tgt_q);

    // Port drive: each channel is active in exactly one controller state.
    assign req_ready = (fs_q == FS_IDLE);
    assign prb_valid = (fs_q == FS_PROBE);
    assign prb_kind  = pkind_q;
    assign prb_node  = pick_idx;
    assign prb_addr  = cur_addr_q;
    assign ack_ready = (fs_q == FS_WAIT);
    assign rsp_valid = (fs_q == FS_REPLY);
    assign rsp_node  = cur_node_q;
    assign rsp_addr  = cur_addr_q;
    assign rsp_data  = data_rd;

    // Store write enables: write-back at evaluation, fetched data on
    // acknowledgement, directory entry when the reply is taken.
    always_comb begin
        dir_we    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = ack_data;
        if (fs_q == FS_EVAL && pol_take) begin
            dir_we    = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = cur_data_q;
        end else if (fs_q == FS_WAIT && ack_valid && pkind_q != PB_INV) begin
            mem_we = 1'b1;
        end else if (fs_q == FS_REPLY && rsp_ready) begin
            dir_we = 1'b1;
        end
    end

    // Controller sequence: idle, evaluate, probe/wait loop, reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q       <= FS_IDLE;
            cur_kind_q <= '0;
            cur_node_q <= '0;
            cur_addr_q <= '0;
            cur_data_q <= '0;
            pend_q     <= '0;
            pkind_q    <= '0;
            nst_q      <= '0;
            nhld_q     <= '0;
            tgt_q      <= '0;
        end else begin
            case (fs_q)
                FS_IDLE: begin
                    if (req_valid) begin
                        cur_kind_q <= req_kind;
                        cur_node_q <= req_node;
                        cur_addr_q <= req_addr;
                        cur_data_q <= req_data;
                        fs_q       <= FS_EVAL;
                    end
                end
                FS_EVAL: begin
                    pend_q  <= pol_mask;
                    pkind_q <= pol_pkind;
                    nst_q   <= pol_nst;
                    nhld_q  <= pol_nhld;
                    if (!pol_reply)          fs_q <= FS_IDLE;
                    else if (pol_mask != '0) fs_q <= FS_PROBE;
                    else                     fs_q <= FS_REPLY;
                end
                FS_PROBE: begin
                    if (prb_ready) begin
                        tgt_q <= pick_idx;
                        fs_q  <= FS_WAIT;
                    end
                end
                FS_WAIT: begin
                    if (ack_valid) begin
                        pend_q <= pend_left;
                        fs_q   <= (pend_left != '0) ? FS_PROBE : FS_REPLY;
                    end
                end
                FS_REPLY: begin
                    if (rsp_ready) fs_q <= FS_IDLE;
                end
                default: fs_q <= FS_IDLE;
            endcase
        end
    end

    AST_PRB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        prb_valid && !prb_ready |=> prb_valid && $stable(prb_node) &&
        $stable(prb_kind) && $stable(prb_addr));                          // R9
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
        $stable(rsp_node) && $stable(rsp_addr));                          // R9
    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_valid || ack_ready || rsp_valid) |-> !req_ready);            // R8
    AST_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        prb_valid |-> prb_node != rsp_node);                              // R10
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({prb_valid, ack_ready, rsp_valid}) <= 1);              // R7

endmodule

// File: tb/sim_coh_home_dir.sv
module sim_coh_home_dir;

    localparam int CLK_PERIOD = 10;
    localparam int NODES  = 4;
    localparam int BLOCKS = 4;
    localparam int DATA_W = 16;
    localparam int NID_W  = 2;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = '0;
    logic [NID_W-1:0]  req_node = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              prb_valid;
    logic              prb_ready = 1'b0;
    logic [1:0]        prb_kind;
    logic [NID_W-1:0]  prb_node;
    logic [ADDR_W-1:0] prb_addr;
    logic              ack_valid = 1'b0;
    logic              ack_ready;
    logic [DATA_W-1:0] ack_data = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [NID_W-1:0]  rsp_node;
    logic [ADDR_W-1:0] rsp_addr;
    logic [DATA_W-1:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 0;

    // Reference model: 0 Uncached, 1 Shared, 2 Exclusive.
    int                m_st  [BLOCKS];
    logic [NODES-1:0]  m_hld [BLOCKS];
    logic [DATA_W-1:0] m_mem [BLOCKS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    coh_home_dir #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_node(req_node), .req_addr(req_addr), .req_data(req_data),
        .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_kind(prb_kind),
        .prb_node(prb_node), .prb_addr(prb_addr),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string tg, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tg, act, exp);
        end
    endtask

    // One transaction; starts and ends just after a falling edge.
    task automatic do_txn(input int kind, input int node, input int addr,
                          input logic [DATA_W-1:0] wdata, input string dtag);
        logic [NODES-1:0] me, mask, nhld;
        int pk, nst, d, pn, pkd;
        bit reply, take;
        logic [DATA_W-1:0] ad, rd;
        me = NODES'(1) << node;
        mask = '0; pk = 0; reply = 0; take = 0;
        nst = m_st[addr]; nhld = m_hld[addr];
        case (kind)
            0: begin
                reply = 1; nst = 1; nhld = m_hld[addr] | me;
                if (m_st[addr] == 2) begin mask = m_hld[addr] & ~me; pk = 1; end
            end
            1: begin
                reply = 1; nst = 2; nhld = me;
                mask = m_hld[addr] & ~me; pk = (m_st[addr] == 2) ? 2 : 0;
            end
            2: if (m_st[addr] == 2 && m_hld[addr] == me) begin
                take = 1; nst = 0; nhld = '0;
            end
            default: ;
        endcase
        chk(req_ready == 1'b1, "R8 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1; req_kind = 2'(kind); req_node = NID_W'(node);
        req_addr = ADDR_W'(addr); req_data = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready && !prb_valid && !rsp_valid, "R8 busy while evaluating",
            {29'd0, req_ready, prb_valid, rsp_valid}, 0);
        @(negedge clk);
        if (!reply) begin
            chk(req_ready && !prb_valid && !rsp_valid, take ? "R5 wb no reply" : "R6 no effect",
                {29'd0, req_ready, prb_valid, rsp_valid}, 4);
            if (take) m_mem[addr] = wdata;
            m_st[addr] = nst; m_hld[addr] = nhld;
            return;
        end
        for (int n = 0; n < NODES; n++) begin
            if (mask[n]) begin
                chk(prb_valid == 1'b1, "R7 probe due", int'(prb_valid), 1);
                chk(int'(prb_node) == n, "R7 probe order", int'(prb_node), n);
                chk(int'(prb_kind) == pk, pk == 0 ? "R3 probe kind" : "R4 probe kind",
                    int'(prb_kind), pk);
                chk(int'(prb_addr) == addr, "R7 probe addr", int'(prb_addr), addr);
                chk(n != node, "R10 requester probed", n, node);
                pn = int'(prb_node); pkd = int'(prb_kind);
                d = int'($urandom % 3);
                for (int w = 0; w < d; w++) begin
                    @(negedge clk);
                    chk(prb_valid && int'(prb_node) == pn && int'(prb_kind) == pkd,
                        "R9 probe hold", int'(prb_node), pn);
                end
                prb_ready = 1'b1;
                @(negedge clk);
                prb_ready = 1'b0;
                chk(!prb_valid && !rsp_valid && !req_ready, "R7 wait for ack",
                    {29'd0, prb_valid, rsp_valid, req_ready}, 0);
                d = int'($urandom % 3);
                for (int w = 0; w < d; w++) begin
                    @(negedge clk);
                    chk(!prb_valid && !req_ready, "R8 hold while waiting",
                        {30'd0, prb_valid, req_ready}, 0);
                end
                ad = DATA_W'($urandom);
                ack_valid = 1'b1; ack_data = ad;
                if (pk != 0) m_mem[addr] = ad;
                @(negedge clk);
                ack_valid = 1'b0;
            end
        end
        chk(rsp_valid == 1'b1 && !prb_valid, mask == 0 ? "R2 reply timing" : "R7 reply after acks",
            int'(rsp_valid), 1);
        chk(int'(rsp_node) == node && int'(rsp_addr) == addr, "R2 reply target",
            int'(rsp_node), node);
        chk(rsp_data == m_mem[addr], dtag, int'(rsp_data), int'(m_mem[addr]));
        rd = rsp_data;
        d = int'($urandom % 3);
        for (int w = 0; w < d; w++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_data == rd, "R9 reply hold", int'(rsp_data), int'(rd));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready && !rsp_valid, "R8 idle after reply", int'(req_ready), 1);
        m_st[addr] = nst; m_hld[addr] = nhld;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        for (int b = 0; b < BLOCKS; b++) begin
            m_st[b] = 0; m_hld[b] = '0; m_mem[b] = '0;
        end
        repeat (3) @(negedge clk);
        chk(req_ready && !prb_valid && !rsp_valid, "R1 in reset",
            {29'd0, req_ready, prb_valid, rsp_valid}, 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !prb_valid && !rsp_valid, "R1 after reset",
            {29'd0, req_ready, prb_valid, rsp_valid}, 4);

        // Directed corner cases.
        do_txn(0, 1, 0, '0, "R1 zero data");        // Uncached read
        do_txn(0, 2, 0, '0, "R2 shared read data");
        do_txn(1, 3, 0, '0, "R3 write after shared"); // invalidates 1,2
        do_txn(0, 0, 0, '0, "R4 fetched data");      // fetch from owner 3
        do_txn(1, 1, 0, '0, "R4 write to shared pair"); // invalidates 0,3
        do_txn(1, 2, 0, '0, "R4 fetch-inv data");    // fetch-inv from 1
        do_txn(2, 1, 0, 16'hdead, "R6");             // non-owner write-back
        do_txn(3, 2, 0, 16'hbeef, "R6");             // no-op kind
        do_txn(2, 2, 0, 16'h1234, "R5");             // owner write-back
        do_txn(0, 3, 0, '0, "R5 wb data visible");   // no probes, 1234
        do_txn(2, 3, 0, 16'h5555, "R6");             // write-back to Shared
        do_txn(0, 0, 0, '0, "R6 data unchanged");
        do_txn(1, 3, 1, '0, "R3 write to uncached");
        do_txn(1, 3, 1, '0, "R10 owner rewrite");    // no self probe
        do_txn(0, 2, 2, '0, "R2 read");
        do_txn(1, 2, 2, '0, "R10 sole sharer write");

        // Constrained random mix.
        for (int t = 0; t < 400; t++) begin
            int k, nd, a;
            k = int'($urandom % 8);
            a = int'($urandom % BLOCKS);
            nd = int'($urandom % NODES);
            if (k < 3) k = 0; else if (k < 6) k = 1; else if (k < 7) k = 2; else k = 3;
            if (k == 2 && m_st[a] == 2 && ($urandom % 4) != 0) begin
                for (int n = 0; n < NODES; n++) if (m_hld[a][n]) nd = n;
            end
            do_txn(k, nd, a, DATA_W'($urandom), "R4 random reply data");
        end

        fin = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule